// File: doc/BRIEF.md
# Boundary-Control Test Operation Register

This block is an 11-bit control register loaded through the scan chain. It chooses one of a small set of built-in test operations and then carries that operation out on an 8-bit data slice. The register has two stages. A shadow stage is shifted serially while the data register is selected. An active stage takes a copy of the shadow stage on the update strobe and drives the operation decoder. Capture leaves both stages untouched.

The upper eight bits of the register are per-input mask flags. The lower three bits are an operation code. There are three operations: pseudo-random pattern generation, signature compaction of the eight data inputs with optional per-input masking, and a binary up-counter. All of them use one 8-bit engine, and the engine's state is visible on `pattern_out`. The engine steps once per clock, but only while the controller sits in its run/idle state with the run-test instruction loaded. At power-up, and whenever the test-logic reset is asserted, both register stages return to a value that selects unmasked signature analysis, and the engine returns to its seed.

Top module: `bctl_test_reg`

## Requirements
- R1: While `rst_n` is low, and on any clock with `tlr` high, both register stages load 11'b00000000010 and `pattern_out` loads the seed 8'h01. After reset, `scan_out` is 0 and unmasked signature analysis is active.
- R2: On a clock with `dr_sel` and `dr_shift` both high, the shadow stage moves one place toward bit 0, and `scan_in` enters bit 10. `scan_out` always shows shadow bit 0, so a bit shifted in appears at `scan_out` after 11 shifts.
- R3: A capture strobe changes neither stage. Shift and update strobes have no effect while `dr_sel` is low.
- R4: On a clock with `dr_sel` and `dr_update` high, the active stage copies the shadow stage. The running operation uses the new code from the next clock on. Shifting alone never changes the running operation.
- R5: Opcode 3'b000 (active bits 2..0, bit 2 most significant) generates patterns: the state becomes {s[6:0], s[7]^s[5]^s[4]^s[3]}.
- R6: Opcode 3'b010 compacts signatures. The state becomes the R5 step XOR (data_in AND NOT mask). Active bit 3+i is the mask for `data_in[i]`, so bit 10 masks `data_in[7]` and bit 3 masks `data_in[0]`. A set mask bit makes its input contribute 0.
- R7: Opcode 3'b011 counts: the state becomes s+1 modulo 256, so 8'hFF wraps to 8'h00.
- R8: Opcodes 3'b001, 3'b100, 3'b101, 3'b110 and 3'b111 hold the state unchanged.
- R9: The engine state changes only on clocks where `rti` and `run_instr` are both high, or where a reset applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; everything updates on its rising edge |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr | input | 1 | Controller is in test-logic reset (synchronous reset) |
| dr_sel | input | 1 | This register is the selected data register |
| dr_capture | input | 1 | Controller is in the capture state of the data path |
| dr_shift | input | 1 | Controller is in the shift state of the data path |
| dr_update | input | 1 | Controller is in the update state of the data path |
| rti | input | 1 | Controller is in run-test/idle |
| run_instr | input | 1 | Run-test instruction is loaded |
| scan_in | input | 1 | Serial input to shadow bit 10 |
| scan_out | output | 1 | Serial output from shadow bit 0 |
| data_in | input | 8 | Data slice compacted in signature mode |
| pattern_out | output | 8 | Engine state: pattern, signature or count |

## Verification
The bench aims at the edges between shifting and running. A new code is shifted in but not yet updated, and the engine must keep its old operation; a design that decoded the shadow stage would switch early. Masking is tested one input at a time: with bit 10 set, an input driven only on `data_in[7]` must leave a pure pattern-generation sequence, and a reversed mask order would corrupt the signature. The counter is driven across 8'hFF, the reserved opcodes and the run-instruction gate are each held for several clocks, and a test-logic reset is applied mid-run; any of these done wrongly moves `pattern_out` or leaves a stale value in the register.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

    // Width of the operation-code field at the bottom of the register.
    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OPC_PRPG  = 3'b000;
    localparam logic [OP_W-1:0] OPC_PSA   = 3'b010;
    localparam logic [OP_W-1:0] OPC_COUNT = 3'b011;

    // Decoded engine mode.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_PRPG  = 2'd1,
        MODE_PSA   = 2'd2,
        MODE_COUNT = 2'd3
    } mode_e;

endpackage

// File: rtl/bctl_scan_stage.sv
// Shadow (shift) and active (update) stages of the control register.
module bctl_scan_stage #(
    parameter int          CL        = 11,
    parameter logic [CL-1:0] RESET_VAL = 11'b00000000010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tlr,
    input  logic          dr_sel,
    input  logic          dr_shift,
    input  logic          dr_update,
    input  logic          scan_in,
    output logic [CL-1:0] shadow,
    output logic [CL-1:0] active,
    output logic          scan_out
);

    typedef struct packed {
        logic [CL-1:0] shadow;
        logic [CL-1:0] active;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tlr) begin
            st_d.shadow = RESET_VAL;
            st_d.active = RESET_VAL;
        end else if (dr_sel) begin
            if (dr_shift) begin
                st_d.shadow = {scan_in, st_q.shadow[CL-1:1]};
            end
            if (dr_update) begin
                st_d.active = st_q.shadow;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shadow <= RESET_VAL;
            st_q.active <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow   = st_q.shadow;
    assign active   = st_q.active;
    assign scan_out = st_q.shadow[0];

endmodule

// File: rtl/bctl_decode.sv
// Splits the active register into masks and a decoded operation mode.
module bctl_decode
    import bctl_pkg::*;
#(
    parameter int W  = 8,
    localparam int CL = W + OP_W
) (
    input  logic [CL-1:0] ctrl,
    output mode_e         mode,
    output logic [W-1:0]  mask
);

    logic [OP_W-1:0] opc;

    assign opc  = ctrl[OP_W-1:0];
    assign mask = ctrl[CL-1:OP_W];

    always_comb begin
        case (opc)
            OPC_PRPG:  mode = MODE_PRPG;
            OPC_PSA:   mode = MODE_PSA;
            OPC_COUNT: mode = MODE_COUNT;
            default:   mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/bctl_engine.sv
// Shared LFSR / signature / counter state for the data slice.
module bctl_engine
    import bctl_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'b1011_1000,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tlr,
    input  logic         advance,
    input  mode_e        mode,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] state
);

    typedef struct packed {
        logic [W-1:0] sig;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic [W-1:0]  tap_bits;
    logic [W-1:0]  gated_in;
    logic          feedback;
    logic [W-1:0]  lfsr_next;

    // Per-input gating and per-stage tap selection.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gated_in[i] = data_in[i] & ~mask[i];
        assign tap_bits[i] = eng_q.sig[i] & TAPS[i];
    end

    assign feedback  = ^tap_bits;
    assign lfsr_next = {eng_q.sig[W-2:0], feedback};

    always_comb begin
        eng_d = eng_q;
        if (tlr) begin
            eng_d.sig = SEED;
        end else if (advance) begin
            case (mode)
                MODE_PRPG:  eng_d.sig = lfsr_next;
                MODE_PSA:   eng_d.sig = lfsr_next ^ gated_in;
                MODE_COUNT: eng_d.sig = eng_q.sig + W'(1);
                default:    eng_d.sig = eng_q.sig;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.sig <= SEED;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign state = eng_q.sig;

endmodule

// File: rtl/bctl_test_reg.sv
// Boundary-control register with its built-in test-operation engine.
module bctl_test_reg
    import bctl_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'b1011_1000,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tlr,
    input  logic         dr_sel,
    input  logic         dr_capture,
    input  logic         dr_shift,
    input  logic         dr_update,
    input  logic         rti,
    input  logic         run_instr,
    input  logic         scan_in,
    output logic         scan_out,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] pattern_out
);

    localparam int            CL        = W + OP_W;
    localparam logic [CL-1:0] RESET_VAL = {{W{1'b0}}, OPC_PSA};

    logic [CL-1:0] ctrl_shadow;
    logic [CL-1:0] ctrl_active;
    mode_e         mode;
    logic [W-1:0]  mask;
    logic          advance;

    // Capture has no effect on this register; the strobe is accepted so
    // the register fits the common data-register interface.
    logic unused_capture;
    assign unused_capture = dr_capture;

    assign advance = rti & run_instr;

    bctl_scan_stage #(
        .CL        (CL),
        .RESET_VAL (RESET_VAL)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .tlr       (tlr),
        .dr_sel    (dr_sel),
        .dr_shift  (dr_shift),
        .dr_update (dr_update),
        .scan_in   (scan_in),
        .shadow    (ctrl_shadow),
        .active    (ctrl_active),
        .scan_out  (scan_out)
    );

    bctl_decode #(
        .W (W)
    ) u_decode (
        .ctrl (ctrl_active),
        .mode (mode),
        .mask (mask)
    );

    bctl_engine #(
        .W    (W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .tlr     (tlr),
        .advance (advance),
        .mode    (mode),
        .mask    (mask),
        .data_in (data_in),
        .state   (pattern_out)
    );

endmodule

// File: rtl/bctl_test_reg_chk.sv
// Temporal checks for bctl_test_reg, attached with bind.
module bctl_test_reg_chk #(
    parameter int W  = 8,
    parameter int CL = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tlr,
    input logic          dr_sel,
    input logic          dr_capture,
    input logic          dr_shift,
    input logic          dr_update,
    input logic          rti,
    input logic          run_instr,
    input logic          scan_out,
    input logic [W-1:0]  pattern_out,
    input logic [CL-1:0] ctrl_shadow,
    input logic [CL-1:0] ctrl_active
);

    localparam logic [CL-1:0] DEF_CTRL = CL'(2);

    logic       run;
    logic [2:0] opc;
    logic       reserved_op;

    assign run         = rti & run_instr;
    assign opc         = ctrl_active[2:0];
    assign reserved_op = (opc != 3'b000) && (opc != 3'b010) && (opc != 3'b011);

    assert_tlr_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tlr |=> (ctrl_shadow == DEF_CTRL) && (ctrl_active == DEF_CTRL));

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_sel && dr_shift && !tlr) |=> scan_out == $past(ctrl_shadow[1]));

    assert_capture_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_sel && dr_capture && !dr_shift && !dr_update && !tlr)
            |=> $stable(ctrl_shadow) && $stable(ctrl_active));

    assert_unselected_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dr_sel && !tlr) |=> $stable(ctrl_shadow) && $stable(ctrl_active));

    assert_update_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_sel && dr_update && !tlr) |=> ctrl_active == $past(ctrl_shadow));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tlr && opc == 3'b011) |=> pattern_out == $past(pattern_out) + W'(1));

    assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tlr && reserved_op) |=> $stable(pattern_out));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !tlr) |=> $stable(pattern_out));

endmodule

bind bctl_test_reg bctl_test_reg_chk #(
    .W  (W),
    .CL (CL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tlr         (tlr),
    .dr_sel      (dr_sel),
    .dr_capture  (dr_capture),
    .dr_shift    (dr_shift),
    .dr_update   (dr_update),
    .rti         (rti),
    .run_instr   (run_instr),
    .scan_out    (scan_out),
    .pattern_out (pattern_out),
    .ctrl_shadow (ctrl_shadow),
    .ctrl_active (ctrl_active)
);

// File: tb/tb_bctl_test_reg.sv
`timescale 1ns/1ps
module tb_bctl_test_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tlr = 1'b0;
    logic       dr_sel = 1'b0;
    logic       dr_capture = 1'b0;
    logic       dr_shift = 1'b0;
    logic       dr_update = 1'b0;
    logic       rti = 1'b0;
    logic       run_instr = 1'b0;
    logic       scan_in = 1'b0;
    logic       scan_out;
    logic [7:0] data_in = 8'h00;
    logic [7:0] pattern_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bctl_test_reg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tlr         (tlr),
        .dr_sel      (dr_sel),
        .dr_capture  (dr_capture),
        .dr_shift    (dr_shift),
        .dr_update   (dr_update),
        .rti         (rti),
        .run_instr   (run_instr),
        .scan_in     (scan_in),
        .scan_out    (scan_out),
        .data_in     (data_in),
        .pattern_out (pattern_out)
    );

    // ---------------- behavioural reference ----------------
    int m_sh  = 2;
    int m_act = 2;
    int m_st  = 1;
    int m_adv = 0;

    function automatic int prpg_step(input int v);
        int fb;
        fb = ((v >> 7) ^ (v >> 5) ^ (v >> 4) ^ (v >> 3)) & 1;
        return ((v << 1) | fb) & 255;
    endfunction

    function automatic int masked_data(input int d, input int ctrl);
        int r;
        r = 0;
        for (int i = 0; i < 8; i++) begin
            if (((d >> i) & 1) == 1 && ((ctrl >> (3 + i)) & 1) == 0) r = r + (1 << i);
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || tlr) begin
            m_sh  <= 2;
            m_act <= 2;
            m_st  <= 1;
            m_adv <= 0;
        end else begin
            if (dr_sel && dr_shift) m_sh <= (m_sh >> 1) | (int'(scan_in) << 10);
            if (dr_sel && dr_update) m_act <= m_sh;
            m_adv <= (rti && run_instr) ? 1 : 0;
            if (rti && run_instr) begin
                case (m_act & 7)
                    0:       m_st <= prpg_step(m_st);
                    2:       m_st <= prpg_step(m_st) ^ masked_data(int'(data_in), m_act);
                    3:       m_st <= (m_st + 1) & 255;
                    default: m_st <= m_st;
                endcase
            end
        end
    end

    // Per-clock comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            if (m_adv == 0)           tag = "R9";
            else if ((m_act & 7) == 0) tag = "R5";
            else if ((m_act & 7) == 2) tag = "R6";
            else if ((m_act & 7) == 3) tag = "R7";
            else                       tag = "R8";
            tests++;
            if (int'(pattern_out) != m_st) begin
                fails++;
                $display("FAIL %s pattern_out actual=%0h expected=%0h", tag, pattern_out, m_st);
            end
            tests++;
            if (int'(scan_out) != (m_sh & 1)) begin
                fails++;
                $display("FAIL R2 scan_out actual=%0d expected=%0d", scan_out, m_sh & 1);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic shift_word(input logic [10:0] v, output logic [10:0] got);
        dr_sel   = 1'b1;
        dr_shift = 1'b1;
        for (int i = 0; i < 11; i++) begin
            scan_in = v[i];
            got[i]  = scan_out;
            @(negedge clk);
        end
        dr_shift = 1'b0;
        dr_sel   = 1'b0;
        scan_in  = 1'b0;
    endtask

    task automatic pulse_update();
        dr_sel    = 1'b1;
        dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
        dr_sel    = 1'b0;
    endtask

    task automatic load_ctrl(input logic [10:0] v);
        logic [10:0] junk;
        shift_word(v, junk);
        pulse_update();
    endtask

    task automatic run_cycles(input int n);
        rti       = 1'b1;
        run_instr = 1'b1;
        repeat (n) @(negedge clk);
        rti       = 1'b0;
        run_instr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [10:0] got;
        int p;
        int e;

        repeat (3) @(negedge clk);
        // R1: reset state on the ports
        check("R1 scan_out after reset", int'(scan_out), 0);
        check("R1 pattern seed after reset", int'(pattern_out), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: shift out the reset value, refilling it
        shift_word(11'b00000000010, got);
        check("R1 reset value shifted out", int'(got), 2);

        // R6: default unmasked signature with varied data
        p = int'(pattern_out);
        e = p;
        for (int k = 0; k < 6; k++) begin
            data_in = 8'(8'h35 * (k + 1));
            e = prpg_step(e) ^ int'(data_in);
            run_cycles(1);
        end
        check("R6 unmasked signature", int'(pattern_out), e);

        // R9: run-state without the run instruction holds
        p = int'(pattern_out);
        rti = 1'b1;
        repeat (4) @(negedge clk);
        rti = 1'b0;
        run_instr = 1'b1;
        repeat (3) @(negedge clk);
        run_instr = 1'b0;
        check("R9 hold outside run", int'(pattern_out), p);

        // R1: test-logic reset restores seed and default
        tlr = 1'b1;
        @(negedge clk);
        tlr = 1'b0;
        check("R1 seed after tlr", int'(pattern_out), 1);

        // R5: pattern generation from the seed, 4 steps -> 8'h11
        load_ctrl(11'b00000000_000);
        run_cycles(4);
        check("R5 prpg 4 steps", int'(pattern_out), 8'h11);

        // R3: capture keeps the shadow; unselected shifting ignored
        dr_sel = 1'b1;
        dr_capture = 1'b1;
        @(negedge clk);
        dr_capture = 1'b0;
        dr_sel = 1'b0;
        dr_shift = 1'b1;
        scan_in = 1'b1;
        repeat (3) @(negedge clk);
        dr_shift = 1'b0;
        dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
        scan_in = 1'b0;
        shift_word(11'b00000000000, got);
        check("R3 shadow after capture", int'(got), 0);
        p = int'(pattern_out);
        run_cycles(1);
        check("R3 active unchanged by unselected update", int'(pattern_out), prpg_step(p));

        // R4: shifted but not updated code is not used
        shift_word(11'b00000000_011, got);
        p = int'(pattern_out);
        run_cycles(2);
        check("R4 old op until update", int'(pattern_out), prpg_step(prpg_step(p)));
        pulse_update();
        p = int'(pattern_out);
        run_cycles(3);
        check("R4 new op after update", int'(pattern_out), (p + 3) & 255);

        // R7: counter wraps past 8'hFF
        p = int'(pattern_out);
        run_cycles(256 - p);
        check("R7 count wrap", int'(pattern_out), 0);

        // R8: reserved codes hold
        for (int c = 0; c < 8; c++) begin
            if (c != 0 && c != 2 && c != 3) begin
                load_ctrl(11'(c));
                p = int'(pattern_out);
                data_in = 8'hA5;
                run_cycles(5);
                check($sformatf("R8 hold opcode %0d", c), int'(pattern_out), p);
            end
        end

        // R6: mask bit 10 gates data_in[7] only
        tlr = 1'b1;
        @(negedge clk);
        tlr = 1'b0;
        load_ctrl(11'b10000000_010);
        data_in = 8'h80;
        p = int'(pattern_out);
        e = p;
        for (int k = 0; k < 7; k++) e = prpg_step(e);
        run_cycles(7);
        check("R6 masked input 8 ignored", int'(pattern_out), e);
        data_in = 8'h01;
        p = int'(pattern_out);
        run_cycles(1);
        check("R6 unmasked input 1 folded", int'(pattern_out), prpg_step(p) ^ 1);

        // R6: all inputs masked behaves as pattern generation
        load_ctrl(11'b11111111_010);
        p = int'(pattern_out);
        for (int k = 0; k < 5; k++) begin
            data_in = 8'(8'h5A + k * 8'h13);
            run_cycles(1);
        end
        e = p;
        for (int k = 0; k < 5; k++) e = prpg_step(e);
        check("R6 fully masked", int'(pattern_out), e);

        // R1: tlr mid-run returns register to default
        rti = 1'b1;
        run_instr = 1'b1;
        tlr = 1'b1;
        @(negedge clk);
        tlr = 1'b0;
        rti = 1'b0;
        run_instr = 1'b0;
        check("R1 seed after tlr mid-run", int'(pattern_out), 1);
        shift_word(11'b00000000010, got);
        check("R1 default after tlr mid-run", int'(got), 2);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule